// File: doc/BRIEF.md
# Security-Register Erase Sequencer for SPI Flash

This block is a host-side SPI master that clears one of the small security registers of an attached serial flash. A one-cycle `start` pulse carries a register index. The block then runs the full command flow without further help. First it sends a write-enable frame. Next it sends the erase frame, which carries the address built from the index. Last it reads status until the device reports that it is idle. At the end it pulses `done` or `err`.

Each command travels in its own chip-select-low frame, and every frame is followed by a guaranteed chip-select-high gap. The serial clock is the system clock divided down. The link uses SPI mode 0: the clock rests low, data leaves on the falling edge, and the device's reply is captured on the rising edge. An index outside the supported range is refused at once and no SPI traffic is generated. Status polling is bounded by a parameter, so a device that never reports ready gives an error and not a hang.

Top module: `sec_erase_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, and `done` and `err` are 0.
- R2: A `start` with `reg_idx` of 0 or above SEC_REG_COUNT (default 3) raises `err` for one cycle on the next clock. `cs_n` then stays high and no frame is sent.
- R3: The first frame of a sequence is exactly 8 bits, carrying the write-enable opcode 0x06, and it ends before the erase frame begins.
- R4: The erase frame is exactly 32 clock pulses: 0x44, 0x00, {reg_idx, 4'b0000}, 0x00, each byte most significant bit first. `cs_n` rises while `sclk` is low after the 32nd pulse, with no further pulse.
- R5: The link is mode 0. `sclk` is 0 whenever `cs_n` is 1 and at each falling edge of `cs_n`, and `mosi` holds steady through every high phase of `sclk`.
- R6: Between two frames of one sequence, `cs_n` stays high for at least CS_GAP system clocks.
- R7: After the erase frame, the block sends status-read frames. Each is 16 pulses: opcode 0x05, then one byte read from `miso`. Bit 0 of that byte is the busy flag. Reads repeat while the flag is 1.
- R8: The first status read with busy flag 0 leads to exactly one `done` pulse. After that no frame is sent, and `err` stays 0.
- R9: If POLL_LIMIT status reads in a row all show busy 1, the block pulses `err` once, sends no further frame, and never raises `done`.
- R10: A `start` that arrives while a sequence is running is ignored. The running sequence keeps its index, and no additional sequence follows.
- R11: While a frame is open, every high phase of `sclk` lasts exactly CLK_DIV system clocks, and every low phase before a rising edge lasts at least CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to erase the indexed register |
| reg_idx | input | 4 | Security register index, valid 1 to SEC_REG_COUNT |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock to the flash |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| done | output | 1 | One-cycle pulse: erase finished and device idle |
| err | output | 1 | One-cycle pulse: index rejected or polling timed out |

## Verification
The hardest cases to reach are the end of polling. One is the exit on the first ready status after several busy replies. The other is the timeout, where every allowed read shows busy. Both depend on what the flash returns in the final bit of a frame. The bench contains a behavioural flash that counts clock pulses per frame and arms a busy counter when it decodes a full erase frame. That counter is set per test, either below or above POLL_LIMIT, so both exits occur with a known number of status frames. A second `start` with a different index is injected during a running sequence, so the erase address in the frame shows whether that request leaked in.

// File: rtl/erase_seq_pkg.sv
// Shared opcodes, state types and frame helpers for the security-register
// erase sequencer. Assumes one-byte opcodes and a 24-bit address field.
package erase_seq_pkg;

    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_SEC_ERASE = 8'h44;
    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] BUSY_MASK    = 8'h01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_XFER,
        ST_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        FR_WREN,
        FR_ERASE,
        FR_STATUS
    } frame_kind_t;

    // Byte sent at position pos of a frame of the given kind.
    function automatic logic [7:0] frame_byte(frame_kind_t kind, logic [3:0] idx,
                                              logic [1:0] pos);
        logic [7:0] b;
        b = 8'h00;
        case (kind)
            FR_WREN:   b = OP_WR_ENABLE;
            FR_ERASE:  begin
                if (pos == 2'd0)      b = OP_SEC_ERASE;
                else if (pos == 2'd2) b = {idx, 4'b0000};
                else                  b = 8'h00;
            end
            FR_STATUS: b = (pos == 2'd0) ? OP_RD_STATUS : 8'h00;
            default:   b = 8'h00;
        endcase
        return b;
    endfunction

    // Position of the final byte of a frame of the given kind.
    function automatic logic [1:0] frame_last(frame_kind_t kind);
        logic [1:0] p;
        case (kind)
            FR_ERASE:  p = 2'd3;
            FR_STATUS: p = 2'd1;
            default:   p = 2'd0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
// Mode-0 byte shifter. A go pulse loads tx_byte while sclk is low. Each
// half period of sclk lasts CLK_DIV system clocks. The engine captures miso
// on rising edges and advances mosi on falling edges. It pulses byte_done
// after the eighth falling edge, leaving sclk low. Assumes go arrives only
// while idle.
module spi_byte_engine #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic             active;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       shreg;

    assign mosi = shreg[7];

    // Divide the clock, toggle sclk, shift data out and in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            div_cnt   <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            rx_byte   <= '0;
            sclk      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    shreg   <= tx_byte;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    sclk    <= 1'b0;
                end
            end else if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        shreg   <= {shreg[6:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    // R5: data must not move while the clock is high
    assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R4: a byte ends with the clock parked low
    assert_byte_ends_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !sclk);

endmodule

// File: rtl/erase_seq_ctrl.sv
// Command sequencer. It checks the index, then runs write-enable, erase and
// repeated status frames, each framed by cs_n. Every frame is followed by a
// CS_GAP cycle high gap. Assumes the byte engine reports one byte_done per go.
module erase_seq_ctrl
    import erase_seq_pkg::*;
#(
    parameter int CS_GAP        = 4,
    parameter int POLL_LIMIT    = 64,
    parameter int SEC_REG_COUNT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] reg_idx,
    input  logic       byte_done,
    input  logic [7:0] rx_byte,
    output logic       go,
    output logic [7:0] tx_byte,
    output logic       cs_n,
    output logic       done,
    output logic       err
);
    localparam int GAP_W  = $clog2(CS_GAP + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    seq_state_t        state;
    frame_kind_t       frame;
    logic [1:0]        pos;
    logic [3:0]        idx_q;
    logic [GAP_W-1:0]  gap_cnt;
    logic [POLL_W-1:0] poll_cnt;
    logic              dev_busy;
    logic              idx_ok;

    assign idx_ok  = (reg_idx != 4'd0) && (reg_idx <= 4'(SEC_REG_COUNT));
    assign go      = (state == ST_LOAD);
    assign tx_byte = frame_byte(frame, idx_q, pos);

    // Step through frames, gaps and the poll decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            frame    <= FR_WREN;
            pos      <= '0;
            idx_q    <= '0;
            gap_cnt  <= '0;
            poll_cnt <= '0;
            dev_busy <= 1'b0;
            cs_n     <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (idx_ok) begin
                            idx_q    <= reg_idx;
                            frame    <= FR_WREN;
                            pos      <= '0;
                            poll_cnt <= '0;
                            cs_n     <= 1'b0;
                            state    <= ST_LOAD;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_LOAD: state <= ST_XFER;
                ST_XFER: begin
                    if (byte_done) begin
                        if (frame == FR_STATUS && pos == 2'd1)
                            dev_busy <= |(rx_byte & BUSY_MASK);
                        if (pos == frame_last(frame)) begin
                            cs_n    <= 1'b1;
                            gap_cnt <= '0;
                            state   <= ST_GAP;
                        end else begin
                            pos   <= pos + 2'd1;
                            state <= ST_LOAD;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_W'(CS_GAP - 1)) begin
                        pos <= '0;
                        case (frame)
                            FR_WREN: begin
                                frame <= FR_ERASE;
                                cs_n  <= 1'b0;
                                state <= ST_LOAD;
                            end
                            FR_ERASE: begin
                                frame <= FR_STATUS;
                                cs_n  <= 1'b0;
                                state <= ST_LOAD;
                            end
                            default: begin
                                if (!dev_busy) begin
                                    done  <= 1'b1;
                                    state <= ST_IDLE;
                                end else if (poll_cnt == POLL_W'(POLL_LIMIT - 1)) begin
                                    err   <= 1'b1;
                                    state <= ST_IDLE;
                                end else begin
                                    poll_cnt <= poll_cnt + POLL_W'(1);
                                    cs_n     <= 1'b0;
                                    state    <= ST_LOAD;
                                end
                            end
                        endcase
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a bad index gives an error with the bus left idle
    assert_bad_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !idx_ok) |=> (err && cs_n));

    // R8: completion and failure never coincide
    assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R9: the poll count stays inside its limit
    assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt < POLL_W'(POLL_LIMIT));

    // R10: a request during a sequence leaves the latched index alone
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> $stable(idx_q));

endmodule

// File: rtl/sec_erase_seq.sv
// Top of the security-register erase sequencer. It joins the command
// sequencer to the mode-0 byte engine. Assumes miso is synchronous to clk
// or slow enough to be sampled directly.
module sec_erase_seq #(
    parameter int CLK_DIV       = 4,
    parameter int CS_GAP        = 4,
    parameter int POLL_LIMIT    = 64,
    parameter int SEC_REG_COUNT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] reg_idx,
    output logic       cs_n,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso,
    output logic       done,
    output logic       err
);
    logic       go;
    logic [7:0] tx_byte;
    logic       byte_done;
    logic [7:0] rx_byte;

    erase_seq_ctrl #(
        .CS_GAP       (CS_GAP),
        .POLL_LIMIT   (POLL_LIMIT),
        .SEC_REG_COUNT(SEC_REG_COUNT)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .reg_idx  (reg_idx),
        .byte_done(byte_done),
        .rx_byte  (rx_byte),
        .go       (go),
        .tx_byte  (tx_byte),
        .cs_n     (cs_n),
        .done     (done),
        .err      (err)
    );

    spi_byte_engine #(
        .CLK_DIV(CLK_DIV)
    ) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .tx_byte  (tx_byte),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .byte_done(byte_done),
        .rx_byte  (rx_byte)
    );

    // R5: the clock rests low whenever the device is deselected
    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4: deselect happens only with the clock low
    assert_cs_rise_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sclk);

endmodule

// File: tb/test_sec_erase_seq.sv
// Bench: a behavioural flash model checked on every clock, plus per-run
// checks of the frames it decoded.
module test_sec_erase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int GAP        = 3;
    localparam int PLIM       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] reg_idx = 4'd0;
    logic       cs_n, sclk, mosi, done, err;
    logic       miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    sec_erase_seq #(.CLK_DIV(DIV), .CS_GAP(GAP), .POLL_LIMIT(PLIM), .SEC_REG_COUNT(3))
        i_sec_erase_seq (.clk(clk), .rst_n(rst_n), .start(start), .reg_idx(reg_idx),
                         .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
                         .done(done), .err(err));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model state
    int          fr_bits = 0;
    logic [31:0] fr_data = '0;
    logic [7:0]  fr_op = '0;
    int          busy_left = 0;
    int          busy_polls = 0;
    bit          model_ready = 0;
    bit          prev_sclk = 0, prev_cs = 1, prev_mosi = 0;
    int          hi_run = 0, lo_run = 0, cs_hi_run = 0;
    int          done_cnt = 0, err_cnt = 0;
    int          frames_in_run = 0;
    int          fr_len_q[$];
    logic [31:0] fr_val_q[$];

    // Reference flash and per-clock protocol comparison.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (cs_n) chk(!sclk, "R5 sclk idle while deselected", 32'(sclk), 0);
            if (prev_cs && !cs_n) begin
                chk(!sclk, "R5 sclk low at select", 32'(sclk), 0);
                if (frames_in_run > 0)
                    chk(cs_hi_run >= GAP, "R6 chip-select gap", cs_hi_run, GAP);
                fr_bits = 0; fr_data = '0; fr_op = '0; lo_run = 0;
            end
            if (prev_sclk && sclk && !cs_n)
                chk(mosi == prev_mosi, "R5 mosi stable while sclk high", 32'(mosi), 32'(prev_mosi));
            if (!prev_sclk && sclk && !cs_n) begin
                chk(lo_run >= DIV, "R11 low phase length", lo_run, DIV);
                fr_bits++;
                fr_data = {fr_data[30:0], mosi};
                if (fr_bits == 8) fr_op = fr_data[7:0];
                hi_run = 0;
            end
            if (prev_sclk && !sclk) begin
                chk(hi_run == DIV, "R11 high phase length", hi_run, DIV);
                lo_run = 0;
            end
            if (sclk) hi_run++; else lo_run++;
            if (!prev_cs || !cs_n) cs_hi_run = 0;
            if (cs_n) cs_hi_run++;
            if (!prev_cs && cs_n) begin
                fr_len_q.push_back(fr_bits);
                fr_val_q.push_back(fr_data);
                frames_in_run++;
                if (fr_bits == 32 && fr_data[31:24] == 8'h44) begin
                    busy_left = busy_polls; model_ready = 0;
                end else if (fr_bits == 16 && fr_op == 8'h05) begin
                    model_ready = (busy_left == 0);
                    if (busy_left > 0) busy_left--;
                end
            end
            miso = (!cs_n && fr_op == 8'h05 && fr_bits == 15) ? (busy_left > 0) : 1'b0;
            if (done) begin
                done_cnt++;
                chk(model_ready, "R8 done only after ready status", 32'(done), 32'(model_ready));
            end
            if (err) err_cnt++;
            chk(!(done && err), "R8 done and err exclusive", {done, err}, 0);
            prev_sclk = sclk; prev_cs = cs_n; prev_mosi = mosi;
        end
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic clear_run();
        fr_len_q.delete(); fr_val_q.delete();
        done_cnt = 0; err_cnt = 0; frames_in_run = 0; model_ready = 0;
    endtask

    task automatic pulse_start(input logic [3:0] idx);
        @(negedge clk);
        start = 1'b1; reg_idx = idx;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_seq(input logic [3:0] idx, input int busy_n, input bit glitch);
        int exp_reads;
        bit exp_done;
        int waited;
        clear_run();
        busy_polls = busy_n;
        exp_done  = (busy_n < PLIM);
        exp_reads = exp_done ? busy_n + 1 : PLIM;
        pulse_start(idx);
        if (glitch) begin
            repeat (10) @(negedge clk);
            pulse_start(4'd3);   // R10: must be ignored
        end
        waited = 0;
        while (done_cnt == 0 && err_cnt == 0 && waited < 20000) begin
            @(negedge clk); waited++;
        end
        repeat (60) @(negedge clk);
        chk(fr_len_q.size() == 2 + exp_reads, "R8 R9 R10 frame count",
            fr_len_q.size(), 2 + exp_reads);
        if (fr_len_q.size() >= 2) begin
            chk(fr_len_q[0] == 8 && fr_val_q[0][7:0] == 8'h06, "R3 write-enable frame",
                fr_val_q[0], 8'h06);
            chk(fr_len_q[1] == 32, "R4 erase frame length", fr_len_q[1], 32);
            chk(fr_val_q[1] == {8'h44, 8'h00, idx, 4'h0, 8'h00}, "R4 R10 erase frame content",
                fr_val_q[1], {8'h44, 8'h00, idx, 4'h0, 8'h00});
            for (int i = 2; i < fr_len_q.size(); i++)
                chk(fr_len_q[i] == 16 && fr_val_q[i][15:8] == 8'h05, "R7 status frame",
                    {fr_len_q[i][15:0], fr_val_q[i][15:0]}, {16'd16, 8'h05, 8'h00});
        end
        chk(done_cnt == (exp_done ? 1 : 0), "R8 done pulses", done_cnt, exp_done ? 1 : 0);
        chk(err_cnt == (exp_done ? 0 : 1), "R9 err pulses", err_cnt, exp_done ? 0 : 1);
    endtask

    task automatic bad_index(input logic [3:0] idx);
        clear_run();
        @(negedge clk);
        start = 1'b1; reg_idx = idx;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, "R2 err after bad index", 32'(err), 1);
        repeat (20) @(negedge clk);
        chk(fr_len_q.size() == 0 && cs_n, "R2 no frame for bad index", fr_len_q.size(), 0);
        chk(err_cnt == 1, "R2 single err pulse", err_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 bus idle after reset", {cs_n, sclk}, 2'b10);
        chk(done == 1'b0 && err == 1'b0, "R1 flags clear after reset", {done, err}, 0);
        bad_index(4'd0);
        bad_index(4'd4);
        bad_index(4'd15);
        run_seq(4'd1, 2, 1'b0);    // R7 busy twice then ready
        run_seq(4'd2, 0, 1'b0);    // R8 ready on first read
        run_seq(4'd3, 10, 1'b0);   // R9 never ready
        run_seq(4'd1, 1, 1'b1);    // R10 second start mid-sequence
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule